// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline with Delayed Branch

This block is a compact in-order processor core built as a five-step pipeline: fetch, decode, execute, memory access and write-back. A new instruction word is taken from the instruction memory on every clock, and no instruction is ever stalled or squashed. The supported operations are: load a word from data memory, store a word to it, load an immediate constant, branch when two registers are equal, and jump unconditionally. Instruction and data memories are outside the block and read combinationally. A small register file sits inside the block.

There is no interlock and no forwarding path. Program order is the only guarantee, so software must place nops between a producer and its consumer. Register-file writes land on the falling clock edge. A result in write-back can therefore be read by decode in the same cycle, which means two nops after a load or immediate load are enough. Branches and jumps are resolved in decode. The word that sits just after them in memory always executes as the delay slot, and a redirected fetch reaches the target in the next cycle. A debug port shows the fetch address and any one register.

Top module: `pipe5_core`

## Requirements
- R1: Instruction word layout: opcode in bits [31:28] (0 nop, 1 load word, 2 store word, 3 load immediate, 4 branch-if-equal, 5 jump), register field A in [27:24], register field B in [23:20], and a 16-bit immediate in [15:0]. Only the low register-index bits of A and B are used. An all-zero word, or any other opcode, writes no register and no memory.
- R2: While `rst_n` is low at a rising edge, the fetch address becomes 0, every pipeline stage holds a nop, and all registers read 0. For three cycles after release, no store reaches the data port.
- R3: One instruction is fetched per clock. When decode does not redirect, the fetch address rises by one each cycle.
- R4: Load word writes data memory at address (register B + immediate) into register A.
- R5: Store word drives register A's value, the address (register B + immediate) and `dmem_we` during the third cycle after the cycle in which it was fetched.
- R6: Load immediate writes the immediate into register A.
- R7: A register write takes effect on the falling clock edge of the write-back cycle. An instruction fetched three cycles after the producer (two nops between them) reads the new value.
- R8: The word after a branch or jump always executes, whether or not control is transferred.
- R9: A taken branch or jump (target = immediate) puts the target on the fetch address in the cycle right after the delay-slot fetch.
- R10: Register 0 always reads zero, and writes to it are discarded.
- R11: `dbg_reg_data` shows the register selected by `dbg_reg_sel` combinationally, and `dbg_pc` shows the current fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pipeline on rising edge, register file on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | IADDR_W | Instruction fetch word address |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | DADDR_W | Data memory word address |
| dmem_wdata | output | DATA_W | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | DATA_W | Load data at `dmem_addr` |
| dbg_pc | output | IADDR_W | Current fetch address |
| dbg_reg_sel | input | REG_AW | Register index to observe |
| dbg_reg_data | output | DATA_W | Value of the selected register |

## Verification
Two pairs of events can fall in the same cycle. In the first, a register is written in write-back while decode reads that same register. In the second, decode resolves a taken branch while fetch is already picking up the delay slot. The test program places consumers exactly two nops after their producers, and a slip of one edge in the write timing then shows up as a wrong stored value. It also fills delay slots with stores and immediate loads, so the slot's effect and the next fetch address are both visible. A behavioural instruction-level model predicts the fetch address and the data-port activity for every cycle, and both are compared on every clock.

// File: rtl/p5_pkg.sv
// Package: shared opcode encoding and instruction field positions.
// Assumes a fixed 32-bit instruction word.
package p5_pkg;
    localparam int INSTR_W = 32;
    localparam int OP_LSB  = 28;
    localparam int FA_LSB  = 24;
    localparam int FB_LSB  = 20;
    localparam int IMM_W   = 16;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LW   = 4'd1,
        OP_SW   = 4'd2,
        OP_LWIM = 4'd3,
        OP_BEQ  = 4'd4,
        OP_JMP  = 4'd5
    } opcode_e;
endpackage

// File: rtl/p5_fetch.sv
// Module: program counter for the fetch stage.
// Assumes the redirect comes from decode and is already final in this cycle.
module p5_fetch #(
    parameter int IADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               redirect,
    input  logic [IADDR_W-1:0] target,
    output logic [IADDR_W-1:0] pc
);
    // Advance by one, or jump to the decoded target.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (redirect) pc <= target;
        else               pc <= pc + 1'b1;
    end
endmodule

// File: rtl/p5_regfile.sv
// Module: register file with two decode read ports and one debug read port.
// Writes land on the falling edge so decode sees them in the same cycle.
// Index 0 is hard-wired to zero.
module p5_regfile #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [REG_AW-1:0] ra1,
    output logic [DATA_W-1:0] rd1,
    input  logic [REG_AW-1:0] ra2,
    output logic [DATA_W-1:0] rd2,
    input  logic [REG_AW-1:0] ra3,
    output logic [DATA_W-1:0] rd3
);
    localparam int NREGS = 1 << REG_AW;

    logic [DATA_W-1:0] regs [NREGS];

    // Falling-edge write; clear all on reset; ignore index 0.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // Combinational reads, index 0 forced to zero.
    always_comb begin
        rd1 = (ra1 == '0) ? '0 : regs[ra1];
        rd2 = (ra2 == '0) ? '0 : regs[ra2];
        rd3 = (ra3 == '0) ? '0 : regs[ra3];
    end
endmodule

// File: rtl/p5_decode.sv
// Module: instruction decode and branch resolution.
// Assumes operand values are already read from the register file. Unknown
// opcodes are turned into nops.
module p5_decode
    import p5_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_AW  = 3,
    parameter int IADDR_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  val_a,
    input  logic [DATA_W-1:0]  val_b,
    output opcode_e            op,
    output logic [REG_AW-1:0]  fa,
    output logic [REG_AW-1:0]  fb,
    output logic [DATA_W-1:0]  imm,
    output logic               redirect,
    output logic [IADDR_W-1:0] target
);
    logic unused_instr;
    assign unused_instr = ^instr;

    // Field extraction and opcode legalisation.
    always_comb begin
        case (instr[OP_LSB +: 4])
            4'd1:    op = OP_LW;
            4'd2:    op = OP_SW;
            4'd3:    op = OP_LWIM;
            4'd4:    op = OP_BEQ;
            4'd5:    op = OP_JMP;
            default: op = OP_NOP;
        endcase
        fa     = instr[FA_LSB +: REG_AW];
        fb     = instr[FB_LSB +: REG_AW];
        imm    = DATA_W'(instr[IMM_W-1:0]);
        target = instr[IADDR_W-1:0];
    end

    // Branch outcome: taken on equal operands or unconditional jump.
    always_comb begin
        redirect = (op == OP_JMP) || ((op == OP_BEQ) && (val_a == val_b));
    end
endmodule

// File: rtl/pipe5_core.sv
// Module: five-stage in-order core (fetch, decode, execute, memory, write-back).
// Assumes hazard-free software: no stalls or forwarding exist; branches have
// one delay slot; memories are external and read combinationally.
module pipe5_core
    import p5_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_AW  = 3,
    parameter int IADDR_W = 8,
    parameter int DADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dmem_we,
    input  logic [DATA_W-1:0]  dmem_rdata,
    output logic [IADDR_W-1:0] dbg_pc,
    input  logic [REG_AW-1:0]  dbg_reg_sel,
    output logic [DATA_W-1:0]  dbg_reg_data
);
    logic [IADDR_W-1:0] pc;
    logic               redirect;
    logic [IADDR_W-1:0] br_target;

    logic [INSTR_W-1:0] id_instr;
    opcode_e            id_op;
    logic [REG_AW-1:0]  id_fa, id_fb;
    logic [DATA_W-1:0]  id_imm, id_va, id_vb;

    opcode_e            ex_op;
    logic [REG_AW-1:0]  ex_rd;
    logic [DATA_W-1:0]  ex_sval, ex_base, ex_imm;

    opcode_e            mm_op;
    logic [REG_AW-1:0]  mm_rd;
    logic [DATA_W-1:0]  mm_addr, mm_val;

    logic               wb_we;
    logic [REG_AW-1:0]  wb_rd;
    logic [DATA_W-1:0]  wb_val;

    logic unused_addr;
    assign unused_addr = ^mm_addr;

    p5_fetch #(.IADDR_W(IADDR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .redirect(redirect),
        .target(br_target), .pc(pc)
    );

    // Fetch -> decode register.
    always_ff @(posedge clk) begin
        if (!rst_n) id_instr <= '0;
        else        id_instr <= imem_rdata;
    end

    p5_decode #(.DATA_W(DATA_W), .REG_AW(REG_AW), .IADDR_W(IADDR_W)) u_dec (
        .instr(id_instr), .val_a(id_va), .val_b(id_vb), .op(id_op),
        .fa(id_fa), .fb(id_fb), .imm(id_imm),
        .redirect(redirect), .target(br_target)
    );

    p5_regfile #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(wb_we), .waddr(wb_rd), .wdata(wb_val),
        .ra1(id_fa), .rd1(id_va), .ra2(id_fb), .rd2(id_vb),
        .ra3(dbg_reg_sel), .rd3(dbg_reg_data)
    );

    // Decode -> execute register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_op <= OP_NOP; ex_rd <= '0; ex_sval <= '0; ex_base <= '0; ex_imm <= '0;
        end else begin
            ex_op <= id_op; ex_rd <= id_fa; ex_sval <= id_va; ex_base <= id_vb; ex_imm <= id_imm;
        end
    end

    // Execute -> memory register: address add, or carry the immediate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mm_op <= OP_NOP; mm_rd <= '0; mm_addr <= '0; mm_val <= '0;
        end else begin
            mm_op   <= ex_op;
            mm_rd   <= ex_rd;
            mm_addr <= ex_base + ex_imm;
            mm_val  <= (ex_op == OP_LWIM) ? ex_imm : ex_sval;
        end
    end

    // Data port driven from the memory stage.
    always_comb begin
        dmem_addr  = mm_addr[DADDR_W-1:0];
        dmem_wdata = mm_val;
        dmem_we    = (mm_op == OP_SW);
    end

    // Memory -> write-back register: choose load data or immediate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_we <= 1'b0; wb_rd <= '0; wb_val <= '0;
        end else begin
            wb_we  <= (mm_op == OP_LW) || (mm_op == OP_LWIM);
            wb_rd  <= mm_rd;
            wb_val <= (mm_op == OP_LW) ? dmem_rdata : mm_val;
        end
    end

    assign imem_addr = pc;
    assign dbg_pc    = pc;
endmodule

// File: rtl/pipe5_core_chk.sv
// Module: property checker for pipe5_core, attached by bind.
// Assumes synchronous active-low reset.
module pipe5_core_chk
    import p5_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_AW  = 3,
    parameter int IADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [IADDR_W-1:0] pc,
    input logic               redirect,
    input logic [IADDR_W-1:0] br_target,
    input opcode_e            id_op,
    input opcode_e            ex_op,
    input logic               dmem_we,
    input logic [REG_AW-1:0]  dbg_reg_sel,
    input logic [DATA_W-1:0]  dbg_reg_data
);
    // R2: first cycle after reset starts at address 0 with a nop in decode
    assert_reset_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pc == '0) && (id_op == OP_NOP));

    // R3: sequential fetch when decode does not redirect
    assert_seq_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> pc == $past(pc) + 1'b1);

    // R9: a redirect lands on its target the next cycle
    assert_target_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc == $past(br_target));

    // R5: a store strobe comes only from a store that was in execute
    assert_store_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> $past(ex_op == OP_SW));

    // R10: register 0 never shows a nonzero value
    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_reg_sel == '0) |-> (dbg_reg_data == '0));
endmodule

bind pipe5_core pipe5_core_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW), .IADDR_W(IADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .redirect(redirect), .br_target(br_target),
    .id_op(id_op), .ex_op(ex_op), .dmem_we(dmem_we),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data)
);

// File: tb/test_pipe5_core.sv
`timescale 1ns/100ps
module test_pipe5_core;
    import p5_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr, dmem_addr, dbg_pc;
    logic [31:0] imem_rdata;
    logic [15:0] dmem_wdata, dmem_rdata, dbg_reg_data;
    logic        dmem_we;
    logic [2:0]  dbg_reg_sel = '0;

    logic [31:0] imem [256];
    logic [15:0] dmem [256];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pipe5_core i_pipe5_core (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .dbg_pc(dbg_pc), .dbg_reg_sel(dbg_reg_sel),
        .dbg_reg_data(dbg_reg_data)
    );

    assign imem_rdata = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_addr];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

    // Reference model state
    logic [15:0] mreg [8];
    logic [15:0] mdmem [256];
    logic [7:0]  mpc, mnpc;
    typedef struct { bit we; int addr; int data; } st_t;
    st_t sq [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input opcode_e op, input int a, input int b, input int imm);
        return {op, 4'(a), 4'(b), 4'h0, 16'(imm)};
    endfunction

    // Model: execute the fetched instruction in program order.
    task automatic iss_step();
        logic [31:0] w = imem[mpc];
        int a = int'(w[26:24]);
        int b = int'(w[22:20]);
        logic [15:0] sum = mreg[b] + w[15:0];
        st_t e = '{0, 0, 0};
        bit taken = 0;
        case (w[31:28])
            4'd1: if (a != 0) mreg[a] = mdmem[sum[7:0]];
            4'd2: begin e = '{1, int'(sum[7:0]), int'(mreg[a])}; mdmem[sum[7:0]] = mreg[a]; end
            4'd3: if (a != 0) mreg[a] = w[15:0];
            4'd4: taken = (mreg[a] == mreg[b]);
            4'd5: taken = 1;
            default: ;
        endcase
        sq.push_back(e);
        mpc  = mnpc;
        mnpc = taken ? w[7:0] : mnpc + 8'd1;
    endtask

    task automatic model_reset();
        foreach (mreg[i]) mreg[i] = '0;
        mpc = 8'd0; mnpc = 8'd1;
        sq.delete();
        for (int i = 0; i < 3; i++) sq.push_back('{0, 0, 0});
    endtask

    // Hold reset, check reset state, release aligned to a sample point.
    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        for (int r = 0; r < 8; r++) begin
            dbg_reg_sel = 3'(r);
            #0.1;
            chk(dbg_reg_data == 16'd0, "R2", $sformatf("reg%0d after reset", r), dbg_reg_data, 0);
        end
        @(posedge clk); #1;
        chk(imem_addr == 8'd0, "R2", "fetch address in reset", imem_addr, 0);
        chk(dmem_we == 1'b0, "R2", "store strobe in reset", dmem_we, 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Compare fetch address and data port against the model every clock.
    task automatic run(input int n);
        logic [7:0] prev = 8'hFF;
        for (int c = 0; c < n; c++) begin
            st_t e;
            chk(imem_addr == mpc, (c == 0 || mpc == prev + 8'd1) ? "R3" : "R9",
                "fetch address", imem_addr, mpc);
            chk(dbg_pc == mpc, "R11", "debug pc", dbg_pc, mpc);
            prev = mpc;
            iss_step();
            e = sq.pop_front();
            chk(dmem_we == e.we, e.we ? "R5" : "R1", "store strobe", dmem_we, e.we);
            if (e.we) begin
                chk(dmem_addr == e.addr[7:0], "R5", "store address", dmem_addr, e.addr);
                chk(dmem_wdata == e.data[15:0], "R5 R7", "store data", dmem_wdata, e.data);
            end
            @(posedge clk); #1;
        end
    endtask

    task automatic load_program();
        foreach (imem[i]) imem[i] = '0;
        foreach (dmem[i]) begin dmem[i] = '0; mdmem[i] = '0; end
        dmem[10] = 16'd7;  mdmem[10] = 16'd7;
        dmem[11] = 16'd7;  mdmem[11] = 16'd7;
        dmem[12] = 16'd9;  mdmem[12] = 16'd9;
        imem[0]  = enc(OP_LW,   1, 0, 10);
        imem[1]  = enc(OP_LW,   2, 0, 11);
        imem[2]  = enc(OP_LWIM, 4, 0, 4);
        imem[3]  = enc(OP_LWIM, 3, 0, 3);
        imem[4]  = enc(OP_BEQ,  1, 2, 8);   // taken
        imem[5]  = enc(OP_LWIM, 5, 0, 5);   // slot
        imem[6]  = enc(OP_JMP,  0, 0, 9);
        imem[7]  = enc(OP_SW,   4, 0, 20);
        imem[8]  = enc(OP_SW,   3, 0, 20);
        imem[9]  = '0;
        imem[10] = enc(OP_SW,   5, 0, 21);
        imem[11] = enc(OP_LW,   6, 0, 12);
        imem[12] = enc(OP_LWIM, 0, 0, 15);  // write to r0 discarded
        imem[13] = '0;
        imem[14] = enc(OP_BEQ,  1, 6, 30);  // not taken
        imem[15] = enc(OP_SW,   0, 0, 22);  // slot
        imem[16] = enc(OP_JMP,  0, 0, 20);
        imem[17] = enc(OP_SW,   6, 0, 23);  // slot
        imem[18] = enc(OP_SW,   1, 0, 24);
        imem[19] = enc(OP_SW,   1, 0, 24);
        imem[20] = enc(OP_LW,   7, 1, 3);   // base r1=7 -> address 10
        imem[21] = enc(OP_LWIM, 1, 0, 100);
        imem[22] = '0;
        imem[23] = '0;
        imem[24] = enc(OP_SW,   7, 1, 0);
        imem[25] = enc(OP_JMP,  0, 0, 25);
        imem[26] = '0;
    endtask

    task automatic final_checks();
        int expv [8] = '{0, 100, 7, 3, 4, 5, 9, 7};
        string req [8] = '{"R10", "R6", "R4", "R6", "R6", "R8", "R4", "R4"};
        for (int r = 0; r < 8; r++) begin
            dbg_reg_sel = 3'(r);
            #0.1;
            chk(dbg_reg_data == expv[r][15:0], req[r], $sformatf("reg%0d", r), dbg_reg_data, expv[r]);
            chk(dbg_reg_data == mreg[r], "R11", $sformatf("reg%0d vs model", r), dbg_reg_data, mreg[r]);
        end
        chk(dmem[20] == 16'd3, "R9", "taken branch path", dmem[20], 3);
        chk(dmem[21] == 16'd5, "R8", "slot value used", dmem[21], 5);
        chk(dmem[22] == 16'd0, "R10", "store of r0", dmem[22], 0);
        chk(dmem[23] == 16'd9, "R8", "jump slot store", dmem[23], 9);
        chk(dmem[24] == 16'd0, "R9", "skipped stores", dmem[24], 0);
        chk(dmem[100] == 16'd7, "R7", "two-nop consumer", dmem[100], 7);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        load_program();
        do_reset();
        run(70);
        final_checks();
        do_reset();            // reset with stores in flight
        run(12);
        do_reset();
        run(70);
        final_checks();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule